// File: doc/BRIEF.md
# Multi-Channel Audio Capture Receive Buffer

This block is the receive end of a capture peripheral for up to four audio channels. Upstream decimation logic delivers 24-bit samples, each with the index of the channel it came from. The samples go into a small first-in first-out buffer. Software drains the buffer one word at a time through a holding register on a simple 32-bit register bus. Each word carries the sample in bits [23:0] and the channel index, zero-extended, in bits [31:24].

The buffer level drives six event flags: data available, buffer empty, buffer full, burst threshold reached, read-while-empty and write-while-full. A set/clear pair of registers builds an enable mask. A single interrupt line is high whenever an event flag and its mask bit are both set. A threshold field in the mode register gives the word count at which a DMA engine may fetch a burst.

The sample input is a valid/ready stream. Its ready output is always high, so the block never applies back-pressure. A sample that finds the buffer full, with no read freeing a slot in the same cycle, is discarded and recorded as an overrun. The bus uses a one-cycle strobe, `bus_en`, qualified by `bus_we`. Read data appears on `bus_rdata` in the cycle after the strobe and holds until the next read.

Top module: `audio_rx_fifo`

## Requirements
- R1: Every cycle with `smp_valid` high offers one sample, and `smp_ready` is always 1. Reads of the holding register (offset 0x0C) return accepted samples in arrival order, formatted as {8-bit zero-extended channel, 24-bit sample}. Each such read removes one word.
- R2: Read data is registered. It appears on `bus_rdata` one cycle after the read strobe. Unmapped offsets and the configuration offset 0x08 read as 0.
- R3: Status register (offset 0x20) live bits: bit 0 is set when the level is above 0, bit 1 when the level is 0, and bit 2 when the level equals DEPTH. The level never exceeds DEPTH.
- R4: Mode register (offset 0x04) bits [31:28] hold the burst threshold; the other mode bits read 0. Status bit 3 is set when the level is at least the threshold, and a threshold of 0 counts as 1.
- R5: A sample that arrives while the buffer is full, with no holding-register read in the same cycle, is discarded. It sets status bit 5 (overrun).
- R6: A holding-register read while the buffer is empty returns 0, leaves the level at 0 and sets status bit 4 (underrun).
- R7: Bits 4 and 5 stay set until the status register is read. That read returns them set and then clears them, unless a new event arrives in the same cycle.
- R8: Writing 1s to offset 0x14 sets the matching mask bits. Writing 1s to offset 0x18 clears them. Offset 0x1C reads the mask, and writes to 0x1C are ignored.
- R9: `irq` is 1 exactly when (status AND mask) is nonzero.
- R10: Writing control offset 0x00 with bit 0 set empties the buffer and clears bits 4 and 5, and leaves the mask and threshold unchanged. A control write with bit 0 clear has no effect.
- R11: Offset 0x50 returns the VERSION parameter in bits [11:0], with 0 above.
- R12: After reset the buffer is empty, the mask is 0, the threshold field is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Always 1; the block never stalls the source |
| smp_data | input | 24 | Decimated sample |
| smp_chan | input | 2 | Channel index of the sample |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the full boundary. The overrun flag must latch while a sample is discarded, and the discarded word must be missing from the later drain. The stimulus fills the buffer to exactly DEPTH words, offers one more, and then drains everything against a scoreboard queue that never received the extra sample. The sticky flags are then checked twice: first as a status read that returns them set, then as a status read that returns them clear. The empty-read underrun path is handled the same way.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int unsigned BUS_AW = 8;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned NFLAGS = 6;

  localparam logic [BUS_AW-1:0] OFS_CTRL = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_MODE = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_CONF = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_HOLD = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_MSET = 8'h14;
  localparam logic [BUS_AW-1:0] OFS_MCLR = 8'h18;
  localparam logic [BUS_AW-1:0] OFS_MASK = 8'h1C;
  localparam logic [BUS_AW-1:0] OFS_STAT = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_VERS = 8'h50;

  // Bit order is fixed by software: ovr=5 .. avail=0
  typedef struct packed {
    logic ovr;
    logic udr;
    logic burst;
    logic full;
    logic empty;
    logic avail;
  } arx_flags_t;
endpackage

// File: rtl/arx_fifo.sv
module arx_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 26,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] head_data,
  output logic          push_drop,
  output logic          pop_under,
  output logic [LW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop, is_full, is_empty;

  assign is_full   = (level == LW'(DEPTH));
  assign is_empty  = (level == '0);
  assign do_pop    = pop_req && !is_empty;
  assign do_push   = push_req && (!is_full || do_pop);
  assign push_drop = push_req && !do_push;
  assign pop_under = pop_req && is_empty;
  assign head_data = mem[rd_ptr];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (do_push && !flush && wr_ptr == PW'(i)) mem[i] <= push_data;
      end
    end
  endgenerate
endmodule

// File: rtl/arx_flags.sv
module arx_flags
  import arx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [LW-1:0]     level,
  input  logic [3:0]        burst_sz,
  input  logic              ovr_evt,
  input  logic              udr_evt,
  input  logic              stat_rd,
  input  logic              mask_set,
  input  logic              mask_clr,
  input  logic [NFLAGS-1:0] mask_bits,
  output logic [NFLAGS-1:0] stat_vec,
  output logic [NFLAGS-1:0] mask_vec,
  output logic              irq
);
  arx_flags_t fl;
  logic       ovr_q, udr_q;
  logic [4:0] thr;

  assign thr = (burst_sz == 4'd0) ? 5'd1 : {1'b0, burst_sz};

  always_comb begin
    fl.avail = (level != '0);
    fl.empty = (level == '0);
    fl.full  = (level == LW'(DEPTH));
    fl.burst = (32'(level) >= 32'(thr));
    fl.udr   = udr_q;
    fl.ovr   = ovr_q;
  end
  assign stat_vec = fl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      udr_q <= 1'b0;
    end else if (flush) begin
      ovr_q <= 1'b0;
      udr_q <= 1'b0;
    end else begin
      ovr_q <= ovr_evt || (ovr_q && !stat_rd);
      udr_q <= udr_evt || (udr_q && !stat_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_vec <= '0;
    else if (mask_set) mask_vec <= mask_vec | mask_bits;
    else if (mask_clr) mask_vec <= mask_vec & ~mask_bits;
  end

  assign irq = |(stat_vec & mask_vec);
endmodule

// File: rtl/arx_regs.sv
module arx_regs
  import arx_pkg::*;
#(
  parameter logic [11:0] VERSION = 12'h1A3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic [NFLAGS-1:0] stat_vec,
  input  logic [NFLAGS-1:0] mask_vec,
  input  logic [BUS_DW-1:0] hold_word,
  output logic              flush,
  output logic              pop_req,
  output logic              stat_rd,
  output logic              mask_set,
  output logic              mask_clr,
  output logic [NFLAGS-1:0] mask_bits,
  output logic [3:0]        burst_sz,
  output logic [BUS_DW-1:0] bus_rdata
);
  logic wr, rd;
  logic [BUS_DW-1:0] rd_mux;

  assign wr        = bus_en && bus_we;
  assign rd        = bus_en && !bus_we;
  assign flush     = wr && (bus_addr == OFS_CTRL) && bus_wdata[0];
  assign mask_set  = wr && (bus_addr == OFS_MSET);
  assign mask_clr  = wr && (bus_addr == OFS_MCLR);
  assign mask_bits = bus_wdata[NFLAGS-1:0];
  assign pop_req   = rd && (bus_addr == OFS_HOLD);
  assign stat_rd   = rd && (bus_addr == OFS_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_sz <= 4'd0;
    else if (wr && bus_addr == OFS_MODE) burst_sz <= bus_wdata[31:28];
  end

  always_comb begin
    unique case (bus_addr)
      OFS_MODE: rd_mux = {burst_sz, 28'd0};
      OFS_HOLD: rd_mux = hold_word;
      OFS_MASK: rd_mux = {{(BUS_DW-NFLAGS){1'b0}}, mask_vec};
      OFS_STAT: rd_mux = {{(BUS_DW-NFLAGS){1'b0}}, stat_vec};
      OFS_VERS: rd_mux = {20'd0, VERSION};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/audio_rx_fifo.sv
module audio_rx_fifo
  import arx_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned SMP_W   = 24,
  parameter int unsigned CH_W    = 2,
  parameter logic [11:0] VERSION = 12'h1A3,
  localparam int unsigned LW     = $clog2(DEPTH + 1),
  localparam int unsigned EW     = CH_W + SMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic [CH_W-1:0]   smp_chan,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              irq
);
  logic              flush, pop_req, stat_rd, mask_set, mask_clr;
  logic              push_drop, pop_under;
  logic [NFLAGS-1:0] mask_bits, flag_vec, mask_vec;
  logic [3:0]        burst_sz;
  logic [LW-1:0]     fifo_level;
  logic [EW-1:0]     head;
  logic [BUS_DW-1:0] hold_word;

  assign smp_ready = 1'b1;

  arx_fifo #(.DEPTH(DEPTH), .DW(EW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_req(smp_valid), .push_data({smp_chan, smp_data}),
    .pop_req(pop_req), .head_data(head),
    .push_drop(push_drop), .pop_under(pop_under), .level(fifo_level)
  );

  assign hold_word = (fifo_level == '0) ? '0 :
                     {8'(head[EW-1:SMP_W]), (BUS_DW-8)'(head[SMP_W-1:0])};

  arx_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .flush(flush), .level(fifo_level),
    .burst_sz(burst_sz), .ovr_evt(push_drop), .udr_evt(pop_under),
    .stat_rd(stat_rd), .mask_set(mask_set), .mask_clr(mask_clr),
    .mask_bits(mask_bits), .stat_vec(flag_vec), .mask_vec(mask_vec), .irq(irq)
  );

  arx_regs #(.VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_vec(flag_vec),
    .mask_vec(mask_vec), .hold_word(hold_word), .flush(flush),
    .pop_req(pop_req), .stat_rd(stat_rd), .mask_set(mask_set),
    .mask_clr(mask_clr), .mask_bits(mask_bits), .burst_sz(burst_sz),
    .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/arx_checker.sv
module arx_checker
  import arx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LW    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              bus_en,
  input logic              bus_we,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [BUS_DW-1:0] bus_wdata,
  input logic              irq,
  input logic [LW-1:0]     level,
  input logic [NFLAGS-1:0] status,
  input logic [NFLAGS-1:0] mask
);
  logic hold_rd, flush_wr;
  assign hold_rd  = bus_en && !bus_we && bus_addr == OFS_HOLD;
  assign flush_wr = bus_en && bus_we && bus_addr == OFS_CTRL && bus_wdata[0];

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  assert_drop_sets_ovr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && level == LW'(DEPTH) && !hold_rd && !flush_wr)
      |=> (status[5] && level == LW'(DEPTH)));

  assert_empty_read_udr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_rd && level == '0) |=> status[4]);

  assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == OFS_MSET)
      |=> ((mask & $past(bus_wdata[NFLAGS-1:0])) == $past(bus_wdata[NFLAGS-1:0])));

  assert_irq_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(status & mask));

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_wr |=> (level == '0 && !status[5] && !status[4]));
endmodule

bind audio_rx_fifo arx_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .bus_en(bus_en),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq),
  .level(fifo_level), .status(flag_vec), .mask(mask_vec)
);

// File: tb/test_audio_rx_fifo.sv
`timescale 1ns/100ps
module test_audio_rx_fifo;
  localparam int DEPTH = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0, smp_ready;
  logic [23:0] smp_data = '0;
  logic [1:0]  smp_chan = '0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;

  int checks = 0, failures = 0;
  logic [31:0] sb[$];
  int lvl = 0, thr = 1;
  bit m_ovr = 0, m_udr = 0;

  always #2.5 clk = ~clk;

  audio_rx_fifo i_audio_rx_fifo (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .smp_chan(smp_chan), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat();
    return {26'd0, m_ovr, m_udr, lvl >= thr, lvl == DEPTH, lvl == 0, lvl != 0};
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0; d = bus_rdata;
  endtask

  // driver: offers a sample and records what the scoreboard expects
  task automatic drive(input logic [1:0] ch, input logic [23:0] s);
    @(negedge clk); smp_valid = 1; smp_chan = ch; smp_data = s;
    @(negedge clk); smp_valid = 0;
    if (lvl < DEPTH) begin sb.push_back({6'd0, ch, s}); lvl++; end
    else m_ovr = 1;
  endtask

  // monitor: pops the holding register and compares with the queue
  task automatic monitor_pop(input string req);
    logic [31:0] d;
    bus_read(8'h0C, d);
    if (lvl == 0) begin m_udr = 1; check(req, d, 32'd0); end
    else begin lvl--; check(req, d, sb.pop_front()); end
  endtask

  task automatic check_stat(input string req);
    logic [31:0] d;
    bus_read(8'h20, d);
    check(req, d, exp_stat());
    m_ovr = 0; m_udr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    check("R12 irq", {31'd0, irq}, 32'd0);
    check("R1 ready", {31'd0, smp_ready}, 32'd1);
    check_stat("R12 R3 reset status");
    bus_read(8'h1C, d); check("R12 mask", d, 32'd0);
    bus_read(8'h04, d); check("R12 mode", d, 32'd0);
    bus_read(8'h50, d); check("R11 version", d, 32'h0000_01A3);
    bus_read(8'h08, d); check("R2 config reads 0", d, 32'd0);
    // R4 threshold 0 counts as 1
    drive(2'd0, 24'h123456); drive(2'd1, 24'hABCDEF); drive(2'd2, 24'h000001);
    check_stat("R4 R3 three words thr=1");
    bus_write(8'h04, 32'h4FFF_FFFF); thr = 4;
    bus_read(8'h04, d); check("R4 mode readback", d, 32'h4000_0000);
    check_stat("R4 below threshold");
    drive(2'd3, 24'hFEDCBA);
    check_stat("R4 at threshold");
    for (int i = 0; i < 4; i++) monitor_pop("R1 drain order");
    // R6 underrun, R7 sticky clear
    monitor_pop("R6 empty read");
    check_stat("R6 R7 underrun set");
    check_stat("R7 underrun cleared");
    // R5 overrun at full boundary
    for (int i = 0; i < DEPTH; i++) drive(2'(i), 24'(32'h10_0000 + i * 7));
    check_stat("R3 full");
    drive(2'd3, 24'hDEAD00);
    check_stat("R5 R7 overrun set");
    check_stat("R7 overrun cleared");
    for (int i = 0; i < DEPTH; i++) monitor_pop("R5 dropped word absent");
    // R8 / R9 mask and irq
    bus_write(8'h14, 32'h0000_0002);
    bus_read(8'h1C, d); check("R8 mask set", d, 32'h2);
    check("R9 irq on empty", {31'd0, irq}, 32'd1);
    bus_write(8'h1C, 32'h0000_003F);
    bus_read(8'h1C, d); check("R8 mask write ignored", d, 32'h2);
    bus_write(8'h18, 32'h0000_0002);
    check("R9 irq off", {31'd0, irq}, 32'd0);
    bus_write(8'h14, 32'h0000_0001);
    check("R9 masked avail idle", {31'd0, irq}, 32'd0);
    drive(2'd1, 24'h0000AA);
    check("R9 irq on avail", {31'd0, irq}, 32'd1);
    // R10 control writes
    bus_write(8'h00, 32'h0000_0000);
    check_stat("R10 no-op control write");
    drive(2'd2, 24'h0000BB);
    bus_write(8'h00, 32'h0000_0001);
    lvl = 0; sb.delete();
    check_stat("R10 soft reset empties");
    bus_read(8'h1C, d); check("R10 mask kept", d, 32'h1);
    bus_read(8'h04, d); check("R10 threshold kept", d, 32'h4000_0000);
    check("R10 R9 irq low after flush", {31'd0, irq}, 32'd0);
    drive(2'd3, 24'h777777);
    monitor_pop("R10 R1 after flush");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule